// File: doc/BRIEF.md
# Indexed Load/Store Address Generator

This block computes the memory address and the updated base-register value for a load or store that moves one register. It takes the base register value and an offset. The offset is either a 12-bit unsigned immediate or a register value shifted left by a 5-bit count. A direction flag chooses whether the offset is added to the base or subtracted from it.

An indexing-mode flag selects one of two modes. In pre-indexed mode the access goes to the offset address, and the base register takes that same address only when writeback is requested. In post-indexed mode the access goes to the unmodified base, and the base register always takes the offset address.

The block is purely combinational. It sits between operand read and the memory request stage of a pipeline. All outputs follow the inputs within the same cycle.

Top module: `lsag_addr_gen`

## Requirements
- R1: When `use_reg_ofs` is 0, the offset is `imm_ofs` zero-extended to 32 bits, so 0xFFF adds 4095.
- R2: When `use_reg_ofs` is 1, the offset is `reg_ofs` logically shifted left by `shamt` (0 to 31). A count of 0 leaves it unshifted, and bits moved past bit 31 are lost.
- R3: `ofs_add` = 1 adds the offset to `base_val` and `ofs_add` = 0 subtracts it. This applies to both immediate and register offsets.
- R4: With `pre_idx` = 1, `eff_addr` equals `base_val` plus or minus the offset.
- R5: With `pre_idx` = 1, `base_we` equals `wb_req` and `next_base` equals `eff_addr`.
- R6: With `pre_idx` = 0, `eff_addr` equals `base_val` unmodified.
- R7: With `pre_idx` = 0, `base_we` is 1 whatever `wb_req` is, and `next_base` equals `base_val` plus or minus the offset.
- R8: Address arithmetic wraps modulo 2^32 in both directions.
- R9: All outputs depend only on the current inputs and settle within the cycle they are applied. The block holds no state.
- R10: While `use_reg_ofs` is 0, `reg_ofs` and `shamt` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| base_val | input | 32 | Current base register value |
| use_reg_ofs | input | 1 | 1 selects the shifted register offset, 0 selects the immediate |
| imm_ofs | input | 12 | Unsigned immediate offset |
| reg_ofs | input | 32 | Register offset value |
| shamt | input | 5 | Left-shift count applied to the register offset |
| ofs_add | input | 1 | 1 adds the offset, 0 subtracts it |
| pre_idx | input | 1 | 1 selects pre-indexed mode, 0 selects post-indexed mode |
| wb_req | input | 1 | Writeback request; it has an effect only in pre-indexed mode |
| eff_addr | output | 32 | Address used for the memory access |
| next_base | output | 32 | Value to be written into the base register |
| base_we | output | 1 | Base register write enable |

## Verification
The access address and the base writeback value are produced in the same cycle, and they must agree or differ depending on the indexing mode. Agreement is required in pre-indexed mode. In post-indexed mode the two must differ by exactly the offset. The bench provokes both cases by applying the same base and offset in each mode in consecutive cycles, with `wb_req` both set and clear. Every cycle the scoreboard compares both outputs and the enable against a model built from the requirements. The bound checker separately enforces the relations between the address and the writeback value that each mode requires.

// File: rtl/lsag_pkg.sv
// Package: shared constants and enumerations for the load/store address generator.
// Assumes a byte-addressed flat address space whose width is set by LSAG_ADDR_W.
package lsag_pkg;
    localparam int LSAG_ADDR_W  = 32;
    localparam int LSAG_IMM_W   = 12;
    localparam int LSAG_SHAMT_W = 5;

    // Which operand supplies the offset
    typedef enum logic {
        OFS_IMM = 1'b0,
        OFS_REG = 1'b1
    } ofs_src_e;

    // Indexing mode: when the base is applied to the access
    typedef enum logic {
        IDX_POST = 1'b0,
        IDX_PRE  = 1'b1
    } idx_mode_e;
endpackage

// File: rtl/lsag_offset_sel.sv
// Module: offset selector. Produces the full-width offset from either a
// zero-extended immediate or a register shifted left by a barrel shifter.
// Assumes SHAMT_W stages are enough to cover shifts up to ADDR_W-1.
module lsag_offset_sel #(
    parameter int ADDR_W  = 32,
    parameter int IMM_W   = 12,
    parameter int SHAMT_W = 5
) (
    input  logic                src_reg,
    input  logic [IMM_W-1:0]    imm_ofs,
    input  logic [ADDR_W-1:0]   reg_ofs,
    input  logic [SHAMT_W-1:0]  shamt,
    output logic [ADDR_W-1:0]   offset
);
    localparam int PAD_W = ADDR_W - IMM_W;

    logic [ADDR_W-1:0] stage [SHAMT_W+1];
    logic [ADDR_W-1:0] imm_ext;

    assign stage[0] = reg_ofs;

    // Barrel shifter: stage s shifts by 2**s when shamt bit s is set
    for (genvar s = 0; s < SHAMT_W; s++) begin : g_shift
        localparam int STEP = 1 << s;
        assign stage[s+1] = shamt[s] ? (stage[s] << STEP) : stage[s];
    end

    // Zero-extend the unsigned immediate
    assign imm_ext = {{PAD_W{1'b0}}, imm_ofs};

    // Pick the offset source
    always_comb begin
        offset = src_reg ? stage[SHAMT_W] : imm_ext;
    end
endmodule

// File: rtl/lsag_addsub.sv
// Module: wrapping adder/subtractor. Subtraction is done as addition of
// the inverted operand with a carry-in of one; the carry-out is discarded.
module lsag_addsub #(
    parameter int ADDR_W = 32
) (
    input  logic              do_add,
    input  logic [ADDR_W-1:0] a,
    input  logic [ADDR_W-1:0] b,
    output logic [ADDR_W-1:0] sum
);
    logic [ADDR_W-1:0] b_eff;
    logic              cin;

    // Condition the second operand for add or subtract
    always_comb begin
        b_eff = do_add ? b : ~b;
        cin   = ~do_add;
    end

    // Single carry-propagate add; the carry-out is dropped, so the result wraps
    always_comb begin
        sum = a + b_eff + {{(ADDR_W-1){1'b0}}, cin};
    end
endmodule

// File: rtl/lsag_index_sel.sv
// Module: indexing-mode selector. Chooses the access address and the
// writeback value and enable from the base and the offset base.
module lsag_index_sel #(
    parameter int ADDR_W = 32
) (
    input  logic              pre_mode,
    input  logic              wb_req,
    input  logic [ADDR_W-1:0] base_val,
    input  logic [ADDR_W-1:0] moved,
    output logic [ADDR_W-1:0] eff_addr,
    output logic [ADDR_W-1:0] next_base,
    output logic              base_we
);
    import lsag_pkg::*;

    idx_mode_e mode;

    // Decode the mode flag
    always_comb mode = idx_mode_e'(pre_mode);

    // Route the addresses and the enable according to the mode
    always_comb begin
        next_base = moved;
        if (mode == IDX_PRE) begin
            eff_addr = moved;
            base_we  = wb_req;
        end else begin
            eff_addr = base_val;
            base_we  = 1'b1;
        end
    end
endmodule

// File: rtl/lsag_addr_gen.sv
// Module: top of the load/store address generator. Combinational: it selects
// the offset, applies it to the base and routes the result by indexing mode.
// It has no clock and no state.
module lsag_addr_gen #(
    parameter int ADDR_W  = lsag_pkg::LSAG_ADDR_W,
    parameter int IMM_W   = lsag_pkg::LSAG_IMM_W,
    parameter int SHAMT_W = lsag_pkg::LSAG_SHAMT_W
) (
    input  logic [ADDR_W-1:0]  base_val,
    input  logic               use_reg_ofs,
    input  logic [IMM_W-1:0]   imm_ofs,
    input  logic [ADDR_W-1:0]  reg_ofs,
    input  logic [SHAMT_W-1:0] shamt,
    input  logic               ofs_add,
    input  logic               pre_idx,
    input  logic               wb_req,
    output logic [ADDR_W-1:0]  eff_addr,
    output logic [ADDR_W-1:0]  next_base,
    output logic               base_we
);
    logic [ADDR_W-1:0] offset;
    logic [ADDR_W-1:0] moved;

    lsag_offset_sel #(
        .ADDR_W (ADDR_W),
        .IMM_W  (IMM_W),
        .SHAMT_W(SHAMT_W)
    ) u_ofs (
        .src_reg(use_reg_ofs),
        .imm_ofs(imm_ofs),
        .reg_ofs(reg_ofs),
        .shamt  (shamt),
        .offset (offset)
    );

    lsag_addsub #(.ADDR_W(ADDR_W)) u_add (
        .do_add(ofs_add),
        .a     (base_val),
        .b     (offset),
        .sum   (moved)
    );

    lsag_index_sel #(.ADDR_W(ADDR_W)) u_idx (
        .pre_mode (pre_idx),
        .wb_req   (wb_req),
        .base_val (base_val),
        .moved    (moved),
        .eff_addr (eff_addr),
        .next_base(next_base),
        .base_we  (base_we)
    );
endmodule

// File: rtl/lsag_addr_gen_chk.sv
// Module: assertion checker bound to lsag_addr_gen. Checks the relations
// between the ports that each indexing mode requires, using immediate assertions.
module lsag_addr_gen_chk #(
    parameter int ADDR_W  = 32,
    parameter int IMM_W   = 12,
    parameter int SHAMT_W = 5
) (
    input logic [ADDR_W-1:0]  base_val,
    input logic               use_reg_ofs,
    input logic [IMM_W-1:0]   imm_ofs,
    input logic [ADDR_W-1:0]  reg_ofs,
    input logic [SHAMT_W-1:0] shamt,
    input logic               ofs_add,
    input logic               pre_idx,
    input logic               wb_req,
    input logic [ADDR_W-1:0]  eff_addr,
    input logic [ADDR_W-1:0]  next_base,
    input logic               base_we
);
    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    // Evaluate the port relations whenever any input or output changes
    always_comb begin
        if (!$isunknown({base_val, use_reg_ofs, imm_ofs, reg_ofs, shamt,
                         ofs_add, pre_idx, wb_req})) begin
            // R6
            post_addr_chk: assert (pre_idx || eff_addr == base_val);
            // R7
            post_we_chk: assert (pre_idx || base_we);
            // R5
            pre_we_chk: assert (!pre_idx || base_we == wb_req);
            // R5
            pre_same_chk: assert (!pre_idx || next_base == eff_addr);
            // R10
            imm_zero_chk: assert (use_reg_ofs || imm_ofs != '0 || next_base == base_val);
            // R2
            reg_zero_chk: assert (!use_reg_ofs || reg_ofs != '0 || shamt != '0
                                  || next_base == base_val);
            // R3
            unit_step_chk: assert (use_reg_ofs || imm_ofs != {{(IMM_W-1){1'b0}}, 1'b1}
                || next_base == (ofs_add ? base_val + ONE : base_val - ONE));
        end
    end
endmodule

bind lsag_addr_gen lsag_addr_gen_chk #(
    .ADDR_W (ADDR_W),
    .IMM_W  (IMM_W),
    .SHAMT_W(SHAMT_W)
) u_chk (.*);

// File: tb/tb_lsag_addr_gen.sv
// Bench: scoreboard for lsag_addr_gen. The driver applies each vector just after
// a rising edge and queues the expected result. The monitor compares it at the
// following falling edge.
module tb_lsag_addr_gen;
    localparam int  CLK_PERIOD = 10;
    localparam int  WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] base_val = '0;
    logic        use_reg_ofs = 1'b0;
    logic [11:0] imm_ofs = '0;
    logic [31:0] reg_ofs = '0;
    logic [4:0]  shamt = '0;
    logic        ofs_add = 1'b0;
    logic        pre_idx = 1'b0;
    logic        wb_req = 1'b0;
    logic [31:0] eff_addr;
    logic [31:0] next_base;
    logic        base_we;

    typedef struct {
        logic [31:0] addr;
        logic [31:0] nb;
        logic        we;
        string       tag;
    } exp_t;

    exp_t sb[$];
    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;

    lsag_addr_gen dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // Apply one vector, compute its expected result from the requirements, queue it
    task automatic drive(input logic [31:0] b, input logic ur, input logic [11:0] im,
                         input logic [31:0] ro, input logic [4:0] sh, input logic ad,
                         input logic pr, input logic wb, input string tag);
        exp_t e;
        logic [31:0] ofs, moved;
        @(posedge clk);
        #1;
        base_val = b; use_reg_ofs = ur; imm_ofs = im; reg_ofs = ro;
        shamt = sh; ofs_add = ad; pre_idx = pr; wb_req = wb;
        ofs   = ur ? (ro << sh) : {20'd0, im};
        moved = ad ? b + ofs : b - ofs;
        e.addr = pr ? moved : b;
        e.nb   = moved;
        e.we   = pr ? wb : 1'b1;
        e.tag  = tag;
        sb.push_back(e);
    endtask

    // Monitor: pop and compare at the falling edge, half a cycle after drive
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (eff_addr !== e.addr || next_base !== e.nb || base_we !== e.we) begin
                failures++;
                $display("FAIL %s: got addr=%h nb=%h we=%b expected addr=%h nb=%h we=%b",
                         e.tag, eff_addr, next_base, base_we, e.addr, e.nb, e.we);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got running expected finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        // Idle state while reset is held: all-zero inputs, post-indexed
        repeat (2) @(posedge clk);
        #1;
        checks++;
        if (eff_addr !== 32'h0 || next_base !== 32'h0 || base_we !== 1'b1) begin
            failures++;
            $display("FAIL R7 idle: got addr=%h nb=%h we=%b expected 0 0 1",
                     eff_addr, next_base, base_we);
        end
        rst_n = 1'b1;
        // R1 largest immediate, pre-indexed add, no writeback
        drive(32'h1000, 0, 12'hFFF, 0, 0, 1, 1, 0, "R1");
        // R3 immediate subtract, pre-indexed with writeback
        drive(32'h1000, 0, 12'h004, 0, 0, 0, 1, 1, "R3");
        // R2 register shifted by 2
        drive(32'h100, 1, 0, 32'h3, 5'd2, 1, 1, 1, "R2");
        // R2 shift by 31 drops the upper bit
        drive(32'h0, 1, 0, 32'h3, 5'd31, 1, 1, 0, "R2");
        // R2 shift count of zero
        drive(32'h0, 1, 0, 32'h12345678, 5'd0, 1, 1, 0, "R2");
        // R4 pre-indexed register subtract
        drive(32'h4000, 1, 0, 32'h10, 5'd4, 0, 1, 0, "R4");
        // R6 R7 post-indexed with writeback clear
        drive(32'h2000, 0, 12'h008, 0, 0, 1, 0, 0, "R6");
        // R7 post-indexed register subtract with writeback set
        drive(32'h2000, 1, 0, 32'h10, 5'd0, 0, 0, 1, "R7");
        // R5 same operands pre-indexed, writeback clear then set
        drive(32'h2000, 1, 0, 32'h10, 5'd0, 0, 1, 0, "R5");
        drive(32'h2000, 1, 0, 32'h10, 5'd0, 0, 1, 1, "R5");
        // R8 wrap on add and on subtract
        drive(32'hFFFFFFF0, 0, 12'h020, 0, 0, 1, 1, 1, "R8");
        drive(32'h00000008, 0, 12'h010, 0, 0, 0, 0, 0, "R8");
        // R10 register offset and shift ignored while immediate selected
        drive(32'h5555, 0, 12'h000, 32'hDEADBEEF, 5'd7, 1, 1, 1, "R10");
        drive(32'h5555, 0, 12'h000, 32'h0, 5'd0, 1, 1, 1, "R10");
        // R9 back-to-back changes, each judged in its own cycle
        lfsr = 32'hACE1_1234;
        for (int i = 0; i < 40; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            drive(lfsr, lfsr[3], lfsr[19:8], {lfsr[15:0], lfsr[31:16]}, lfsr[24:20],
                  lfsr[5], lfsr[6], lfsr[7], "R9");
        end
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule